// File: doc/BRIEF.md
# Functional-Unit Latency and Occupancy Scoreboard

This block keeps track, for the issue logic of an in-order core, of when each destination register will hold its result and of how long each iterative execution resource stays occupied. Every accepted issue carries an operation class, a precision bit and a destination register index. The scoreboard marks that register pending for the operation's result latency and, for operations that iterate, holds the matching iterative resource busy for its own occupancy count. That count may be shorter than the latency.

Three iterative resources are tracked independently: the integer multiply/divide iterator, the floating-point multiply iterator and the floating-point divide/square-root iterator. An issue that needs an occupied resource is refused and has no effect. An issue that needs a free resource, or no resource at all, is accepted at once. The issue logic reads a ready flag for each register and a busy flag for each resource.

Top module: `fu_scoreboard`

## Requirements
- R1: After reset every register ready flag is 1, all three busy flags are 0, and an issue with valid=1 is accepted.
- R2: Non-iterative integer classes (issue_op code: latency) are: 0 simple ALU: 1, 1 load: 2, 2 store: 1, 3 branch: 3, 4 move-to-HI/LO: 3, 5 move-from-HI/LO: 1, 6 integer/FP file transfer: 2. Codes 14 and 15 behave like code 0. None of these occupies an iterative resource. A register issued with latency L reads not-ready for exactly L cycles after the accepting edge.
- R3: Multiply classes: code 7 (multiply and multiply-add) has latency 5 and occupancy 3 on the integer iterator when issue_dbl=0, and latency 9 and occupancy 8 when issue_dbl=1. Code 8 (three-operand multiply) has latency 2 and no occupancy when issue_dbl=0, and latency 9 and occupancy 8 on the integer iterator when issue_dbl=1.
- R4: Code 9 (integer divide) has latency and occupancy 36 when issue_dbl=0 and 68 when issue_dbl=1, on the integer iterator.
- R5: Code 10 (FP add, convert, negate, compare, abs, move) has latency 4 and no occupancy. Code 11 (FP multiply) has latency 4 and occupancy 1 when issue_dbl=0, and latency 5 and occupancy 2 when issue_dbl=1, on the FP multiply iterator.
- R6: Code 12 (FP divide/sqrt) has latency and occupancy 21 when single and 36 when double. Code 13 (FP reciprocal sqrt) has 38 when single and 68 when double. Both use the FP divide iterator.
- R7: A resource's busy flag is high for exactly its occupancy count of cycles after the accepting edge. It counts down by one each cycle.
- R8: While the required resource is busy, issue_accept is 0 and the refused issue leaves register flags unchanged. The issue is accepted in the first cycle the busy flag reads 0.
- R9: Register 0 is never marked pending, even when an accepted issue names it. Any occupancy the issue carries is still applied.
- R10: An accepted issue to an already-pending register replaces its remaining count with the new latency.
- R11: The three resources are independent: a busy integer iterator does not block an FP operation, and the reverse holds too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered for issue this cycle |
| issue_op | input | 4 | Operation class code |
| issue_dbl | input | 1 | Precision: 1 = 64-bit / double, 0 = 32-bit / single |
| issue_dest | input | 5 | Destination register index |
| issue_accept | output | 1 | The offered operation is taken at the next edge |
| reg_ready | output | 32 | One ready flag per register |
| int_busy | output | 1 | Integer multiply/divide iterator occupied |
| fmul_busy | output | 1 | FP multiply iterator occupied |
| fdiv_busy | output | 1 | FP divide/sqrt iterator occupied |

## Verification
The assertions assume that a resource is loaded only through an accepted issue, and that the decode never gives a latency of zero. The bench holds issue_valid for exactly the cycles it intends and leaves enough idle time between sweep points that every counter has drained before the next issue. The sweep covers every class code in both precisions and measures each not-ready window and busy window against arithmetic expectations. Directed sequences overlap operations only on purpose, to exercise refusal, resource independence, register zero and counter replacement.

// File: rtl/fusb_pkg.sv
package fusb_pkg;

    localparam int LAT_W  = 7;   // holds counts up to 127
    localparam int NUNIT  = 3;

    typedef enum logic [3:0] {
        OP_ALU    = 4'd0,
        OP_LOAD   = 4'd1,
        OP_STORE  = 4'd2,
        OP_BRANCH = 4'd3,
        OP_MTHL   = 4'd4,
        OP_MFHL   = 4'd5,
        OP_XFER   = 4'd6,
        OP_IMUL   = 4'd7,
        OP_IMUL3  = 4'd8,
        OP_IDIV   = 4'd9,
        OP_FADD   = 4'd10,
        OP_FMUL   = 4'd11,
        OP_FDIV   = 4'd12,
        OP_FRSQ   = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        U_INT  = 2'd0,
        U_FMUL = 2'd1,
        U_FDIV = 2'd2,
        U_NONE = 2'd3
    } unit_e;

    typedef struct packed {
        logic [LAT_W-1:0] lat;
        logic [LAT_W-1:0] occ;
        unit_e            unit;
    } op_info_t;

    function automatic op_info_t mk(int lat, int occ, unit_e u);
        op_info_t r;
        r.lat  = LAT_W'(lat);
        r.occ  = LAT_W'(occ);
        r.unit = u;
        return r;
    endfunction

    function automatic op_info_t decode_op(op_e op, logic dbl);
        case (op)
            OP_LOAD:   return mk(2, 0, U_NONE);
            OP_STORE:  return mk(1, 0, U_NONE);
            OP_BRANCH: return mk(3, 0, U_NONE);
            OP_MTHL:   return mk(3, 0, U_NONE);
            OP_MFHL:   return mk(1, 0, U_NONE);
            OP_XFER:   return mk(2, 0, U_NONE);
            OP_IMUL:   return dbl ? mk(9, 8, U_INT) : mk(5, 3, U_INT);
            OP_IMUL3:  return dbl ? mk(9, 8, U_INT) : mk(2, 0, U_NONE);
            OP_IDIV:   return dbl ? mk(68, 68, U_INT) : mk(36, 36, U_INT);
            OP_FADD:   return mk(4, 0, U_NONE);
            OP_FMUL:   return dbl ? mk(5, 2, U_FMUL) : mk(4, 1, U_FMUL);
            OP_FDIV:   return dbl ? mk(36, 36, U_FDIV) : mk(21, 21, U_FDIV);
            OP_FRSQ:   return dbl ? mk(68, 68, U_FDIV) : mk(38, 38, U_FDIV);
            default:   return mk(1, 0, U_NONE);
        endcase
    endfunction

endpackage

// File: rtl/fusb_iter_unit.sv
module fusb_iter_unit #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load_val,
    output logic          busy
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } iter_st_t;

    iter_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)
            st_d.cnt = load_val;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    // a resource is only ever loaded once idle
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // occupancy drains by exactly one per cycle
    assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/fusb_reg_track.sv
module fusb_reg_track #(
    parameter int NREG = 32,
    parameter int CW   = 7,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic [IW-1:0]   set_idx,
    input  logic [CW-1:0]   set_lat,
    output logic [NREG-1:0] ready
);

    typedef struct packed {
        logic [NREG-1:0][CW-1:0] cnt;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (set && (set_idx == IW'(i)) && (i != 0))
                st_d.cnt[i] = set_lat;
            else if (st_q.cnt[i] != '0)
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_rdy
        assign ready[g] = (st_q.cnt[g] == '0);

        // a ready register only goes pending through an issue naming it
        assert_hold_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ready[g] && !(set && set_idx == IW'(g))) |=> ready[g]);

        if (g != 0) begin : g_set
            assert_set_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (set && set_idx == IW'(g) && set_lat != '0) |=> !ready[g]);
        end
    end

endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard #(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG),
    localparam int CW  = fusb_pkg::LAT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [3:0]      issue_op,
    input  logic            issue_dbl,
    input  logic [IW-1:0]   issue_dest,
    output logic            issue_accept,
    output logic [NREG-1:0] reg_ready,
    output logic            int_busy,
    output logic            fmul_busy,
    output logic            fdiv_busy
);
    import fusb_pkg::*;

    op_info_t         info;
    logic [NUNIT-1:0] unit_busy;
    logic [NUNIT-1:0] unit_start;
    logic             need_free;

    always_comb begin
        info         = decode_op(op_e'(issue_op), issue_dbl);
        need_free    = (info.unit != U_NONE) && unit_busy[info.unit];
        issue_accept = issue_valid && !need_free;
        for (int u = 0; u < NUNIT; u++)
            unit_start[u] = issue_accept && (info.unit == unit_e'(u));
    end

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        fusb_iter_unit #(.CW(CW)) u_iter (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (unit_start[u]),
            .load_val (info.occ),
            .busy     (unit_busy[u])
        );
    end

    fusb_reg_track #(.NREG(NREG), .CW(CW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (issue_accept),
        .set_idx (issue_dest),
        .set_lat (info.lat),
        .ready   (reg_ready)
    );

    assign int_busy  = unit_busy[U_INT];
    assign fmul_busy = unit_busy[U_FMUL];
    assign fdiv_busy = unit_busy[U_FDIV];

    // register zero is never reported pending
    assert_r0_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready[0]);

    // an accepted iterative issue raises its busy flag next cycle
    assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unit_start[U_FDIV] |=> fdiv_busy);

endmodule

// File: tb/fu_scoreboard_tb.sv
module fu_scoreboard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [3:0]  issue_op = '0;
    logic        issue_dbl = 1'b0;
    logic [4:0]  issue_dest = '0;
    logic        issue_accept;
    logic [31:0] reg_ready;
    logic        int_busy, fmul_busy, fdiv_busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fu_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dbl(issue_dbl), .issue_dest(issue_dest), .issue_accept(issue_accept),
        .reg_ready(reg_ready), .int_busy(int_busy), .fmul_busy(fmul_busy),
        .fdiv_busy(fdiv_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] busy_vec();
        return {fdiv_busy, fmul_busy, int_busy};
    endfunction

    // expected latency, occupancy, unit (0 int, 1 fmul, 2 fdiv, 3 none)
    function automatic void expect_op(input int op, input bit dbl,
                                      output int lat, output int occ, output int un);
        occ = 0; un = 3;
        case (op)
            1, 6:  lat = 2;
            3, 4:  lat = 3;
            7:     begin lat = dbl ? 9 : 5; occ = dbl ? 8 : 3; un = 0; end
            8:     begin lat = dbl ? 9 : 2; occ = dbl ? 8 : 0; un = dbl ? 0 : 3; end
            9:     begin lat = dbl ? 68 : 36; occ = lat; un = 0; end
            10:    lat = 4;
            11:    begin lat = dbl ? 5 : 4; occ = dbl ? 2 : 1; un = 1; end
            12:    begin lat = dbl ? 36 : 21; occ = lat; un = 2; end
            13:    begin lat = dbl ? 68 : 38; occ = lat; un = 2; end
            default: lat = 1;
        endcase
    endfunction

    function automatic string req_of(input int op);
        if (op <= 6 || op >= 14) return "R2";
        if (op <= 8) return "R3";
        if (op == 9) return "R4";
        if (op <= 11) return "R5";
        return "R6";
    endfunction

    task automatic issue(input int op, input bit dbl, input int dest);
        @(negedge clk);
        issue_op = op[3:0]; issue_dbl = dbl; issue_dest = dest[4:0]; issue_valid = 1'b1;
    endtask

    task automatic run_op(input int op, input bit dbl);
        int lat, occ, un, lows, highs, stray;
        int dest = 1 + ((op * 2 + int'(dbl)) % 31);
        expect_op(op, dbl, lat, occ, un);
        issue(op, dbl, dest);
        #1 chk(issue_accept == 1'b1, "R1 accept when idle", int'(issue_accept), 1);
        @(posedge clk);
        lows = 0; highs = 0; stray = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            issue_valid = 1'b0;
            if (!reg_ready[dest]) lows++;
            for (int u = 0; u < 3; u++) begin
                if (busy_vec()[u]) begin
                    if (u == un) highs++;
                    else stray++;
                end
            end
        end
        chk(lows == lat, req_of(op), lows, lat);
        chk(highs == occ, "R7 occupancy", highs, occ);
        chk(stray == 0, "R11 other unit busy", stray, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(reg_ready == '1, "R1 ready after reset", int'(reg_ready == '1), 1);
        chk(busy_vec() == 3'b000, "R1 busy after reset", int'(busy_vec()), 0);

        // sweep every class code in both precisions
        for (int op = 0; op < 16; op++)
            for (int d = 0; d < 2; d++)
                run_op(op, d[0]);

        // R8 / R11: refusal while the integer iterator is busy
        issue(9, 1'b0, 3);
        @(negedge clk);
        issue_op = 4'd11; issue_dbl = 1'b1; issue_dest = 5'd4;
        #1 chk(issue_accept == 1'b1, "R11 fmul accepted while int busy", int'(issue_accept), 1);
        @(negedge clk);
        chk(fmul_busy && int_busy, "R11 both busy", int'(busy_vec()), 3);
        issue_op = 4'd7; issue_dbl = 1'b0; issue_dest = 5'd7;
        n = 0;
        #1;
        while (!issue_accept && n < 100) begin
            chk(reg_ready[7] == 1'b1, "R8 refused issue no effect", int'(reg_ready[7]), 1);
            chk(int_busy == 1'b1, "R8 refusal only while busy", int'(int_busy), 1);
            n++;
            @(negedge clk); #1;
        end
        chk(n == 35, "R8 refused cycles", n, 35);
        chk(int_busy == 1'b0, "R8 accept once idle", int'(int_busy), 0);
        @(negedge clk);
        issue_valid = 1'b0;
        chk(reg_ready[7] == 1'b0 && int_busy, "R8 late issue took effect", int'(reg_ready[7]), 0);
        repeat (80) @(negedge clk);

        // R9: register zero never pending, occupancy still applied
        issue(9, 1'b1, 0);
        @(negedge clk);
        issue_valid = 1'b0;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            if (!reg_ready[0]) n++;
            @(negedge clk);
        end
        chk(n == 0, "R9 reg zero stays ready", n, 0);
        chk(int_busy == 1'b1, "R9 occupancy still applied", int'(int_busy), 1);
        repeat (80) @(negedge clk);

        // R10: replacement of a pending count
        issue(12, 1'b0, 9);
        repeat (5) @(negedge clk);
        issue_op = 4'd0; issue_dbl = 1'b0; issue_dest = 5'd9;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(reg_ready[9] == 1'b0, "R10 pending after reissue", int'(reg_ready[9]), 0);
        @(negedge clk);
        chk(reg_ready[9] == 1'b1, "R10 new latency replaces old", int'(reg_ready[9]), 1);
        chk(fdiv_busy == 1'b1, "R7 fdiv still occupied", int'(fdiv_busy), 1);
        repeat (80) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule